// File: doc/BRIEF.md
# Serial Register Control Port

This block is a synchronous serial slave that lets a host read and write a small byte-wide register space over three wires: an active-low select, a serial clock and one data line. The data line is bidirectional. The pad itself sits outside the block, so the block offers the line as a separate input, output and output-enable. The serial clock and data are sampled in the system clock domain, which must run at least four times faster than the serial clock.

Every transaction opens with a 16-bit instruction. The instruction gives the direction, a byte count and a 13-bit start address. Data bytes follow the instruction, and the address steps down by one after each byte. Written bytes go to a shadow copy of each data register, and reads always return the active copy. A self-clearing update bit copies every shadow register into its active register in one system clock. A self-clearing reset bit returns all data registers to their power-on values.

Top module: `serial_ctrl_port`

## Requirements
- R1: A transaction starts when `csn` falls and opens with a 16-bit instruction sent most significant bit first. Bit 15 set to 1 means read and 0 means write. Bits 14:13 are the byte count code: 00 means 1 byte, 01 means 2, 10 means 3 and 11 means streaming. Bits 12:0 are the start address.
- R2: Input bits are sampled on the rising edge of `sclk`. Read data leaves MSB first and changes only after a falling edge of `sclk`. `sdio_oe` is 1 during the data phase of a read and 0 while `csn` is high.
- R3: In a multi-byte transfer the address decrements by one after each byte. Once the counted bytes are done, further `sclk` cycles are ignored until `csn` rises.
- R4: With count code 11 the transfer keeps going, byte after byte at descending addresses, until `csn` rises.
- R5: A write to a data register (address `REG_BASE`+i, for i below `NUM_REGS`) changes only its shadow copy. A read of that address returns the active copy, which stays unchanged until an update.
- R6: Writing a byte with bit 0 set to the update address (`UPD_ADDR`, 0x005) copies all shadow registers to the active registers in a single clock. The update bit then reads back as 0.
- R7: Writing a byte with bit 0 set to the reset address (`RST_ADDR`, 0x000) sets every shadow and active register i to (0x5A + 0x13*i) mod 256. The reset bit then clears itself on the next clock and reads back as 0.
- R8: If `csn` rises partway through a byte, that byte is dropped and nothing is written. The next `csn` fall starts a new instruction, even if the abort came during an instruction.
- R9: Addresses that map to no register read as 0x00, and writes to them have no effect.
- R10: When `rst_n` is low, every register takes its R7 default value and `sdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| csn | input | 1 | Active-low transaction select from the host |
| sclk | input | 1 | Serial clock from the host, slower than `clk` |
| sdio_in | input | 1 | Data line as seen at the pad |
| sdio_out | output | 1 | Read data to drive onto the line |
| sdio_oe | output | 1 | 1 while the block drives the line, 0 for high impedance |

## Verification
The bench builds the block with `NUM_REGS` = 8 and `REG_BASE` = 0x010, with the update bit at 0x005 and the reset bit at 0x000. With this layout, a descending stream written from 0x012 runs off the bottom of the data window into unmapped addresses, which exercises the decrement and the ignore rule in one transfer. A streaming read of eight bytes covers the whole window. Random write, update and read sequences are checked against a shadow/active model kept in the bench, and aborts both inside a data byte and inside an instruction are covered.

// File: rtl/scp_pkg.sv
// Shared constants, types and default values for the serial register control port.
// Assumes a fixed 16-bit instruction: direction bit, two count bits, 13 address bits.
package scp_pkg;

    localparam int INSTR_W = 16;
    localparam int ADDR_W  = 13;
    localparam int BYTE_W  = 8;

    // Phase of the serial transaction
    typedef enum logic [1:0] {
        PH_INSTR = 2'd0,
        PH_DATA  = 2'd1,
        PH_DONE  = 2'd2
    } phase_t;

    // Count code meaning "stream until select rises"
    localparam logic [1:0] CNT_STREAM = 2'b11;

    // Power-on value of data register idx
    function automatic logic [7:0] reg_default(input int idx);
        return 8'(32'h5A + 32'h13 * idx);
    endfunction

endpackage

// File: rtl/scp_edge_detect.sv
// Detects rising and falling edges of the serial clock in the system clock domain.
// Assumes sclk is already synchronous to clk and holds each level for at least two clk cycles.
module scp_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);

    logic sclk_q;

    // Remember the previous level of the serial clock
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;

endmodule

// File: rtl/scp_serial_fsm.sv
// Serial protocol engine: decodes the instruction, counts bytes, shifts data in and out.
// Assumes edge pulses from scp_edge_detect and a combinational read port on the register file.
module scp_serial_fsm
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sdo,
    output logic              oe
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [3:0]        LAST_INSTR_BIT = 4'(INSTR_W - 1);
    localparam logic [3:0]        LAST_DATA_BIT  = 4'(BYTE_W - 1);

    phase_t                phase_q;
    logic [3:0]            bitpos_q;
    logic [INSTR_W-2:0]    ish_q;
    logic [BYTE_W-2:0]     rx_q;
    logic [BYTE_W-1:0]     tx_q;
    logic                  read_q;
    logic [1:0]            cnt_q;
    logic [1:0]            nbyte_q;
    logic [ADDR_W-1:0]     addr_q;
    logic                  wr_en_q;
    logic [ADDR_W-1:0]     wr_addr_q;
    logic [BYTE_W-1:0]     wr_data_q;
    logic                  oe_q;

    // Transaction state, shifting and write strobe generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_INSTR;
            bitpos_q  <= '0;
            ish_q     <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            read_q    <= 1'b0;
            cnt_q     <= '0;
            nbyte_q   <= '0;
            addr_q    <= '0;
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
            oe_q      <= 1'b0;
        end else begin
            wr_en_q <= 1'b0;
            oe_q    <= ~csn && (phase_q == PH_DATA) && read_q;
            if (csn) begin
                phase_q  <= PH_INSTR;
                bitpos_q <= '0;
                nbyte_q  <= '0;
            end else begin
                if (sclk_rise) begin
                    unique case (phase_q)
                        PH_INSTR: begin
                            if (bitpos_q == LAST_INSTR_BIT) begin
                                read_q   <= ish_q[INSTR_W-2];
                                cnt_q    <= ish_q[INSTR_W-3:INSTR_W-4];
                                addr_q   <= {ish_q[ADDR_W-2:0], sdi};
                                phase_q  <= PH_DATA;
                                bitpos_q <= '0;
                            end else begin
                                ish_q    <= {ish_q[INSTR_W-3:0], sdi};
                                bitpos_q <= bitpos_q + 4'd1;
                            end
                        end
                        PH_DATA: begin
                            if (bitpos_q == LAST_DATA_BIT) begin
                                if (!read_q) begin
                                    wr_en_q   <= 1'b1;
                                    wr_addr_q <= addr_q;
                                    wr_data_q <= {rx_q, sdi};
                                end
                                addr_q   <= addr_q - ADDR_ONE;
                                bitpos_q <= '0;
                                nbyte_q  <= nbyte_q + 2'd1;
                                if (cnt_q != CNT_STREAM && nbyte_q == cnt_q)
                                    phase_q <= PH_DONE;
                            end else begin
                                rx_q     <= {rx_q[BYTE_W-3:0], sdi};
                                bitpos_q <= bitpos_q + 4'd1;
                            end
                        end
                        default: ;
                    endcase
                end
                if (sclk_fall && phase_q == PH_DATA && read_q) begin
                    if (bitpos_q == '0) tx_q <= rd_data;
                    else                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign rd_addr = addr_q;
    assign wr_en   = wr_en_q;
    assign wr_addr = wr_addr_q;
    assign wr_data = wr_data_q;
    assign sdo     = tx_q[BYTE_W-1];
    assign oe      = oe_q;

endmodule

// File: rtl/scp_regfile.sv
// Buffered register file: shadow and active copy per data register, plus self-clearing
// update and reset bits. Assumes at most one write strobe per several clk cycles.
module scp_regfile
    import scp_pkg::*;
#(
    parameter int          NUM_REGS = 8,
    parameter int unsigned REG_BASE = 16,
    parameter int unsigned UPD_ADDR = 5,
    parameter int unsigned RST_ADDR = 0,
    localparam int         FLAT_W   = NUM_REGS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [FLAT_W-1:0] shadow_flat,
    output logic [FLAT_W-1:0] active_flat,
    output logic              upd_pend,
    output logic              rst_pend
);

    localparam logic [ADDR_W-1:0] UPD_A = ADDR_W'(UPD_ADDR);
    localparam logic [ADDR_W-1:0] RST_A = ADDR_W'(RST_ADDR);

    logic upd_q;
    logic rst_q;

    // Self-clearing update request
    always_ff @(posedge clk) begin
        if (!rst_n)                                    upd_q <= 1'b0;
        else if (upd_q)                                upd_q <= 1'b0;
        else if (wr_en && wr_addr == UPD_A && wr_data[0]) upd_q <= 1'b1;
    end

    // Self-clearing soft reset request
    always_ff @(posedge clk) begin
        if (!rst_n)                                    rst_q <= 1'b0;
        else if (rst_q)                                rst_q <= 1'b0;
        else if (wr_en && wr_addr == RST_A && wr_data[0]) rst_q <= 1'b1;
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_BASE + i);
        localparam logic [BYTE_W-1:0] MY_DEF  = reg_default(i);
        logic [BYTE_W-1:0] shadow_q;
        logic [BYTE_W-1:0] active_q;

        // Shadow copy takes host writes
        always_ff @(posedge clk) begin
            if (!rst_n || rst_q)                    shadow_q <= MY_DEF;
            else if (wr_en && wr_addr == MY_ADDR)   shadow_q <= wr_data;
        end

        // Active copy follows the shadow only on update
        always_ff @(posedge clk) begin
            if (!rst_n || rst_q) active_q <= MY_DEF;
            else if (upd_q)      active_q <= shadow_q;
        end

        assign shadow_flat[i*BYTE_W +: BYTE_W] = shadow_q;
        assign active_flat[i*BYTE_W +: BYTE_W] = active_q;
    end

    // Read multiplexer over active registers and control bits
    always_comb begin
        rd_data = '0;
        if (rd_addr == UPD_A) rd_data = {7'd0, upd_q};
        if (rd_addr == RST_A) rd_data = {7'd0, rst_q};
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(REG_BASE + i)) rd_data = active_flat[i*BYTE_W +: BYTE_W];
        end
    end

    assign upd_pend = upd_q;
    assign rst_pend = rst_q;

endmodule

// File: rtl/serial_ctrl_port.sv
// Top of the serial register control port: edge detection, protocol engine, register file.
// Assumes csn, sclk and sdio_in are synchronous to clk; the pad tri-state lives outside.
module serial_ctrl_port
    import scp_pkg::*;
#(
    parameter int          NUM_REGS = 8,
    parameter int unsigned REG_BASE = 16,
    parameter int unsigned UPD_ADDR = 5,
    parameter int unsigned RST_ADDR = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csn,
    input  logic sclk,
    input  logic sdio_in,
    output logic sdio_out,
    output logic sdio_oe
);

    localparam int FLAT_W = NUM_REGS * BYTE_W;

    logic              sclk_rise;
    logic              sclk_fall;
    logic [ADDR_W-1:0] rd_addr;
    logic [BYTE_W-1:0] rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [FLAT_W-1:0] shadow_flat;
    logic [FLAT_W-1:0] active_flat;
    logic              upd_pend;
    logic              rst_pend;

    scp_edge_detect u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    scp_serial_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .csn       (csn),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi       (sdio_in),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sdo       (sdio_out),
        .oe        (sdio_oe)
    );

    scp_regfile #(
        .NUM_REGS (NUM_REGS),
        .REG_BASE (REG_BASE),
        .UPD_ADDR (UPD_ADDR),
        .RST_ADDR (RST_ADDR)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .shadow_flat (shadow_flat),
        .active_flat (active_flat),
        .upd_pend    (upd_pend),
        .rst_pend    (rst_pend)
    );

endmodule

// File: rtl/scp_checker.sv
// Property checker for serial_ctrl_port, attached with bind below.
// Assumes it sees the register file's flattened copies and pending flags.
module scp_checker
    import scp_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int FLAT_W  = NUM_REGS * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csn,
    input logic              sdio_oe,
    input logic              wr_en,
    input logic              upd_pend,
    input logic              rst_pend,
    input logic [FLAT_W-1:0] shadow_flat,
    input logic [FLAT_W-1:0] active_flat
);

    logic [FLAT_W-1:0] def_flat;

    // Expected power-on image of the data registers
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) def_flat[i*BYTE_W +: BYTE_W] = reg_default(i);
    end

    a_r2_release_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        csn |=> !sdio_oe);

    a_r5_write_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !upd_pend && !rst_pend) |=> $stable(active_flat));

    a_r6_update_copies_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pend && !rst_pend) |=> (active_flat == $past(shadow_flat)));

    a_r6_update_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pend |=> !upd_pend);

    a_r7_reset_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pend |=> !rst_pend);

    a_r7_reset_restores_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pend |=> (active_flat == def_flat && shadow_flat == def_flat));

endmodule

bind serial_ctrl_port scp_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csn         (csn),
    .sdio_oe     (sdio_oe),
    .wr_en       (wr_en),
    .upd_pend    (upd_pend),
    .rst_pend    (rst_pend),
    .shadow_flat (shadow_flat),
    .active_flat (active_flat)
);

// File: tb/serial_ctrl_port_tb.sv
// Self-checking bench: directed corner cases plus seeded random traffic against a bench model.
module serial_ctrl_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int NUM_REGS   = 8;
    localparam int REG_BASE   = 16;
    localparam int UPD_ADDR   = 5;
    localparam int RST_ADDR   = 0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1;
    logic sclk = 1'b0;
    logic sdio_in = 1'b0;
    logic sdio_out;
    logic sdio_oe;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];
    logic       oe_ok;
    logic [7:0] shadow_m [NUM_REGS];
    logic [7:0] active_m [NUM_REGS];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_ctrl_port #(
        .NUM_REGS (NUM_REGS),
        .REG_BASE (REG_BASE),
        .UPD_ADDR (UPD_ADDR),
        .RST_ADDR (RST_ADDR)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .csn      (csn),
        .sclk     (sclk),
        .sdio_in  (sdio_in),
        .sdio_out (sdio_out),
        .sdio_oe  (sdio_oe)
    );

    function automatic logic [7:0] defv(input int i);
        return 8'(32'h5A + 32'h13 * i);
    endfunction

    function automatic logic [15:0] instr(input logic rd, input logic [1:0] cc, input int a);
        return {rd, cc, 13'(a)};
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < NUM_REGS; i++) begin
            shadow_m[i] = defv(i);
            active_m[i] = defv(i);
        end
    endfunction

    function automatic void model_write(input int a, input logic [7:0] d);
        int ma;
        ma = a & 13'h1FFF;
        if (ma >= REG_BASE && ma < REG_BASE + NUM_REGS) shadow_m[ma - REG_BASE] = d;
        else if (ma == UPD_ADDR && d[0]) begin
            for (int i = 0; i < NUM_REGS; i++) active_m[i] = shadow_m[i];
        end else if (ma == RST_ADDR && d[0]) model_reset();
    endfunction

    function automatic logic [7:0] model_read(input int a);
        int ma;
        ma = a & 13'h1FFF;
        if (ma >= REG_BASE && ma < REG_BASE + NUM_REGS) return active_m[ma - REG_BASE];
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // One serial bit: present data, sample line before the rising edge, then raise and drop sclk
    task automatic send_bit(input logic b, output logic got, output logic got_oe);
        @(negedge clk);
        sdio_in = b;
        repeat (HALF) @(negedge clk);
        got    = sdio_out;
        got_oe = sdio_oe;
        sclk   = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk   = 1'b0;
    endtask

    // Raw transaction: ibits instruction bits then dbits data bits, then deselect
    task automatic txn(input logic [15:0] ins, input int ibits, input int dbits);
        logic g, go;
        oe_ok = 1'b1;
        @(negedge clk);
        csn = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < ibits; k++) send_bit(ins[15-k], g, go);
        for (int k = 0; k < dbits; k++) begin
            send_bit(wbuf[k/8][7-(k%8)], g, go);
            rbuf[k/8][7-(k%8)] = g;
            if (ins[15] && !go) oe_ok = 1'b0;
        end
        repeat (2) @(negedge clk);
        csn = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [1:0] cc, input int nb);
        txn(instr(1'b0, cc, a), 16, nb * 8);
        for (int j = 0; j < nb; j++) model_write(a - j, wbuf[j]);
    endtask

    task automatic rd_check(input string req, input int a, input logic [1:0] cc, input int nb);
        txn(instr(1'b1, cc, a), 16, nb * 8);
        for (int j = 0; j < nb; j++) check(req, rbuf[j], model_read(a - j));
        check({req, " oe during read"}, {7'd0, oe_ok}, 8'd1);
    endtask

    task automatic do_update();
        wbuf[0] = 8'h01;
        wr(UPD_ADDR, 2'b00, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (5) @(negedge clk);
        check("R10 oe low in reset", {7'd0, sdio_oe}, 8'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R2 oe low while deselected", {7'd0, sdio_oe}, 8'd0);

        // R10 R1: read all defaults with 3-byte and 2-byte reads
        rd_check("R10 defaults", REG_BASE + 7, 2'b10, 3);
        rd_check("R10 defaults", REG_BASE + 4, 2'b01, 2);
        rd_check("R1 single byte read", REG_BASE + 2, 2'b00, 1);
        check("R2 oe released after read", {7'd0, sdio_oe}, 8'd0);

        // R5 R6: shadow write invisible until update
        wbuf[0] = 8'hC3;
        wr(REG_BASE + 3, 2'b00, 1);
        check("R5 active unchanged before update", model_read(REG_BASE + 3), defv(3));
        rd_check("R5 read before update", REG_BASE + 3, 2'b00, 1);
        do_update();
        rd_check("R6 read after update", REG_BASE + 3, 2'b00, 1);
        check("R6 model after update", model_read(REG_BASE + 3), 8'hC3);
        rd_check("R6 update bit reads zero", UPD_ADDR, 2'b00, 1);

        // R3: three-byte descending write, then reads
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wr(REG_BASE + 7, 2'b10, 3);
        do_update();
        rd_check("R3 descending 3-byte write", REG_BASE + 7, 2'b10, 3);

        // R3: bits after the counted bytes are ignored
        wbuf[0] = 8'h44; wbuf[1] = 8'hEE;
        txn(instr(1'b0, 2'b00, REG_BASE + 1), 16, 16);
        model_write(REG_BASE + 1, 8'h44);
        do_update();
        rd_check("R3 extra byte ignored", REG_BASE + 1, 2'b01, 2);

        // R4 R9: stream off the bottom of the window into unmapped space
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3; wbuf[3] = 8'hA4; wbuf[4] = 8'hA5;
        wr(REG_BASE + 2, 2'b11, 5);
        do_update();
        rd_check("R4 streaming read of window", REG_BASE + 7, 2'b11, 8);
        rd_check("R9 unmapped reads zero", REG_BASE - 1, 2'b01, 2);
        wbuf[0] = 8'h5C;
        wr(13'h1ABC, 2'b00, 1);
        rd_check("R9 unmapped write ignored", 13'h1ABC, 2'b00, 1);

        // R8: abort inside a data byte
        wbuf[0] = 8'hFF;
        txn(instr(1'b0, 2'b00, REG_BASE + 6), 16, 5);
        do_update();
        rd_check("R8 partial byte dropped", REG_BASE + 6, 2'b00, 1);
        // R8: abort inside the instruction, then a clean write
        txn(16'hFFFF, 7, 0);
        wbuf[0] = 8'h6D;
        wr(REG_BASE + 6, 2'b00, 1);
        do_update();
        rd_check("R8 fresh instruction after abort", REG_BASE + 6, 2'b00, 1);

        // Seeded random traffic
        for (int it = 0; it < 60; it++) begin
            int op, a;
            logic [1:0] cc;
            op = int'($urandom % 4);
            a  = REG_BASE + int'($urandom % NUM_REGS);
            cc = 2'($urandom % 3);
            if (op < 2) begin
                for (int j = 0; j < 3; j++) wbuf[j] = 8'($urandom);
                wr(a, cc, int'(cc) + 1);
            end else if (op == 2) begin
                do_update();
            end else begin
                rd_check("R5 random readback", a, cc, int'(cc) + 1);
            end
        end

        // R7: soft reset restores defaults and self-clears
        wbuf[0] = 8'h01;
        wr(RST_ADDR, 2'b00, 1);
        rd_check("R7 defaults after soft reset", REG_BASE + 7, 2'b11, 8);
        check("R7 model defaults", model_read(REG_BASE), defv(0));
        rd_check("R7 reset bit reads zero", RST_ADDR, 2'b00, 1);
        do_update();
        rd_check("R7 shadow also at defaults", REG_BASE + 7, 2'b11, 8);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule